// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block recovers a two-wire serial bus after a transfer was cut short and a target device may still be holding the data line low. When the host logic asks for recovery, the block takes control of the clock line and pulses it, up to a fixed number of times. At each pulse it releases the data line so that it can listen for the target letting go. As soon as the data line reads high during a clock-high phase, the block drives a Start condition followed directly by a Stop. This returns every target on the bus to a known idle state. The block then reports success with a one-cycle done pulse.

If the data line is still low after the last allowed pulse, the block gives up, raises a one-cycle fail pulse and returns to idle. Both bus lines are open-drain, so the block has only "pull low" enables for them and one sense input for the data line. The clock line is never held by anyone but this block. Each clock phase lasts `PHASE_CLKS` system clocks, and the pulse limit is `MAX_PULSES`, which defaults to nine. This block has no data stream, so every pin is a plain control or status signal and no handshake is involved.

Top module: `twb_recover`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `done` and `fail` are all 0.
- R2: A `recover_req` of 1 sampled while idle makes `scl_pull` 1 from the next cycle, for a low phase of `PHASE_CLKS` cycles with `sda_pull` at 0.
- R3: Each low phase is followed by a high phase of `PHASE_CLKS` cycles with both pulls at 0, and `sda_sense` is sampled in the first cycle of that high phase.
- R4: If the sample is 0 and fewer than `MAX_PULSES` high phases have occurred since the request, another low phase follows. There are never more than `MAX_PULSES` clock pulses in one recovery.
- R5: If the sample is 1, then after the high phase `sda_pull` is 1 for `PHASE_CLKS` cycles with `scl_pull` 0; this is the Start. `sda_pull` is never 1 while `scl_pull` is 1.
- R6: After the Start, `sda_pull` returns to 0 with `scl_pull` still 0 for `PHASE_CLKS` cycles; this is the Stop.
- R7: In the cycle after the Stop phase, `done` is 1 for exactly one cycle and the block is idle again.
- R8: If the sample of the `MAX_PULSES`-th high phase is 0, `fail` is 1 for exactly one cycle in the cycle after that phase, and the block is idle again.
- R9: `recover_req` has no effect while a recovery is in progress. While idle, both pulls, `done` and `fail` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recover_req | input | 1 | Start a recovery (sampled only while idle) |
| sda_sense | input | 1 | Level of the data line |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| done | output | 1 | One-cycle pulse: Start and Stop completed |
| fail | output | 1 | One-cycle pulse: data line still low after the last pulse |

## Verification
The first low phase is due in the cycle after the edge that samples `recover_req`. Each later phase follows the one before it exactly `PHASE_CLKS` cycles later. `done` or `fail` comes one cycle after the last phase. The bench builds this whole expected timeline into a queue at the sampling edge, and the queue depends on how many pulses its target model holds the data line for. It then pops one entry and compares it at every falling edge, half a period after the design's registers update. When the queue is empty, the idle outputs are expected, so a request made during a recovery, and any stray pulse, shows up as a mismatch in the cycle where it occurs.

// File: rtl/twb_rcv_pkg.sv
package twb_rcv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_START = 3'd3,
    ST_STOP  = 3'd4
  } rcv_state_t;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/twb_rcv_phase_timer.sv
module twb_rcv_phase_timer
  import twb_rcv_pkg::*;
#(
  parameter int unsigned PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic first,
  output logic last
);
  localparam int unsigned TW = bits_for(PHASE_CLKS);
  localparam logic [TW-1:0] TOP = TW'(PHASE_CLKS - 1);

  logic [TW-1:0] cnt_q;

  // Counts down from TOP to zero; the owner reloads it at each phase change.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TOP;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign first = (cnt_q == TOP);
  assign last  = (cnt_q == '0);
endmodule

// File: rtl/twb_rcv_pulse_cnt.sv
module twb_rcv_pulse_cnt
  import twb_rcv_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_max
);
  localparam int unsigned CW = bits_for(MAX_PULSES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (inc && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_max = (cnt_q == LIMIT);
endmodule

// File: rtl/twb_rcv_fsm.sv
module twb_rcv_fsm
  import twb_rcv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic sda_in,
  input  logic ph_first,
  input  logic ph_last,
  input  logic at_max,
  output logic ph_load,
  output logic cnt_clear,
  output logic cnt_inc,
  output logic scl_pull,
  output logic sda_pull,
  output logic done,
  output logic fail,
  output logic idle
);
  rcv_state_t st_q, st_d;
  logic seen_q;
  logic sda_now;
  logic done_d, fail_d;
  logic done_q, fail_q;

  // When a phase is one clock long, the sample and the decision share an edge.
  assign sda_now = ph_first ? sda_in : seen_q;

  always_comb begin
    st_d      = st_q;
    ph_load   = 1'b0;
    cnt_clear = 1'b0;
    cnt_inc   = 1'b0;
    done_d    = 1'b0;
    fail_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d      = ST_LOW;
          ph_load   = 1'b1;
          cnt_clear = 1'b1;
        end
      end
      ST_LOW: begin
        if (ph_last) begin
          st_d    = ST_HIGH;
          ph_load = 1'b1;
          cnt_inc = 1'b1;
        end
      end
      ST_HIGH: begin
        if (ph_last) begin
          if (sda_now) begin
            st_d    = ST_START;
            ph_load = 1'b1;
          end else if (at_max) begin
            st_d   = ST_IDLE;
            fail_d = 1'b1;
          end else begin
            st_d    = ST_LOW;
            ph_load = 1'b1;
          end
        end
      end
      ST_START: begin
        if (ph_last) begin
          st_d    = ST_STOP;
          ph_load = 1'b1;
        end
      end
      ST_STOP: begin
        if (ph_last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      seen_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      fail_q <= fail_d;
      if (st_q == ST_HIGH && ph_first) begin
        seen_q <= sda_in;
      end
    end
  end

  assign scl_pull = (st_q == ST_LOW);
  assign sda_pull = (st_q == ST_START);
  assign done     = done_q;
  assign fail     = fail_q;
  assign idle     = (st_q == ST_IDLE);
endmodule

// File: rtl/twb_recover.sv
module twb_recover
  import twb_rcv_pkg::*;
#(
  parameter int unsigned PHASE_CLKS = 4,
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic sda_sense,
  output logic scl_pull,
  output logic sda_pull,
  output logic done,
  output logic fail
);
  logic ph_load, ph_first, ph_last;
  logic cnt_clear, cnt_inc, at_max;
  logic fsm_idle;

  twb_rcv_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ph_load),
    .first (ph_first),
    .last  (ph_last)
  );

  twb_rcv_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cnt_clear),
    .inc    (cnt_inc),
    .at_max (at_max)
  );

  twb_rcv_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (recover_req),
    .sda_in    (sda_sense),
    .ph_first  (ph_first),
    .ph_last   (ph_last),
    .at_max    (at_max),
    .ph_load   (ph_load),
    .cnt_clear (cnt_clear),
    .cnt_inc   (cnt_inc),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .done      (done),
    .fail      (fail),
    .idle      (fsm_idle)
  );
endmodule

// File: rtl/twb_recover_chk.sv
module twb_recover_chk #(
  parameter int unsigned MAX_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic fail,
  input logic idle
);
  int unsigned rises;
  logic scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rises <= 0;
      scl_q <= 1'b0;
    end else begin
      scl_q <= scl_oe;
      if (done || fail) rises <= 0;
      else if (scl_oe && !scl_q) rises <= rises + 1;
    end
  end

  AST_REQ_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (req && idle) |=> scl_oe); // R2
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) rises <= MAX_PULSES); // R4
  AST_SDA_ONLY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sda_oe |-> !scl_oe); // R5
  AST_START_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> $past(!scl_oe)); // R5
  AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(sda_oe) |-> !scl_oe); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fail |=> !fail); // R8
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) idle |-> (!scl_oe && !sda_oe)); // R9
endmodule

bind twb_recover twb_recover_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (recover_req),
  .scl_oe (scl_pull),
  .sda_oe (sda_pull),
  .done   (done),
  .fail   (fail),
  .idle   (fsm_idle)
);

// File: tb/tb_twb_recover.sv
`timescale 1ns/1ps
module tb_twb_recover;
  localparam int PH  = 3;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_req = 1'b0;
  logic sda_sense;
  logic scl_pull, sda_pull, done, fail;

  always #4 clk = ~clk;

  twb_recover #(.PHASE_CLKS(PH), .MAX_PULSES(MAXP)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .recover_req (recover_req),
    .sda_sense   (sda_sense),
    .scl_pull    (scl_pull),
    .sda_pull    (sda_pull),
    .done        (done),
    .fail        (fail)
  );

  // Target model: holds the data line low until it has seen more than hold_n clock rises.
  wire scl_line = ~scl_pull;
  int rise_cnt = 0;
  int rise_base = 0;
  int hold_n = 0;
  logic tgt_on = 1'b0;
  always @(posedge scl_line) rise_cnt <= rise_cnt + 1;
  assign sda_sense = ~sda_pull & ~(tgt_on && (rise_cnt - rise_base) <= hold_n);

  int total = 0;
  int bad = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];
  logic checking = 1'b0;
  int cycles = 0;
  logic finished = 1'b0;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {scl,sda,done,fail} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      logic [3:0] e;
      string t;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = 4'b0000;
        t = "R9";
      end
      check({scl_pull, sda_pull, done, fail}, e, t);
    end
  end

  task automatic push_n(input int n, input logic [3:0] v, input string t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  // Expected timeline for a target that stays low for k pulses.
  task automatic push_run(input int k);
    int p;
    p = (k + 1 < MAXP) ? k + 1 : MAXP;
    for (int i = 1; i <= p; i++) begin
      push_n(PH, 4'b1000, (i == 1) ? "R2" : "R4");
      push_n(PH, 4'b0000, "R3");
    end
    if (k < MAXP) begin
      push_n(PH, 4'b0100, "R5");
      push_n(PH, 4'b0000, "R6");
      push_n(1, 4'b0010, "R7");
    end else begin
      push_n(1, 4'b0001, "R8");
    end
  endtask

  task automatic launch(input int k);
    @(posedge clk); #1;
    hold_n = k;
    rise_base = rise_cnt;
    tgt_on = 1'b1;
    recover_req = 1'b1;
    @(posedge clk); #1;
    recover_req = 1'b0;
    push_run(k);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1 tgt_on = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({scl_pull, sda_pull, done, fail}, 4'b0000, "R1");
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check({scl_pull, sda_pull, done, fail}, 4'b0000, "R1");
    checking = 1'b1;

    launch(0); drain();        // R5 target already released
    launch(3); drain();        // R4 several pulses
    launch(MAXP - 1); drain(); // R4 success on the last allowed pulse
    launch(MAXP); drain();     // R8 fail on the boundary
    launch(20); drain();       // R8 target stuck far past the limit

    // R9: requests during a recovery are ignored
    launch(2);
    repeat (PH + 1) @(posedge clk);
    #1 recover_req = 1'b1;
    @(posedge clk); #1 recover_req = 1'b0;
    repeat (4 * PH) @(posedge clk);
    #1 recover_req = 1'b1;
    @(posedge clk); #1 recover_req = 1'b0;
    drain();

    // R9: idle with a stuck target and no request stays quiet
    tgt_on = 1'b1;
    repeat (10) @(posedge clk);
    #1 tgt_on = 1'b0;

    launch(1); drain(); // R7 recovery again after idle
    checking = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule